// File: doc/BRIEF.md
# Dual-Port Service Bridge Control Register Bank

This block holds the 64-bit control registers of a service-interface host bridge: a fault isolation register with its two action registers, a control/status word, the host window base register with its enable, a service-side base register, a status/error-mask word and a DMA upper address word. Two requesters reach the same storage. A scan-style port indexes registers directly by its address. A memory-mapped port sees the same registers shifted by a fixed offset. Some offsets are write-only aliases that AND or OR data into the fault register, or set or clear bits in the control word.

Each port has a valid/ready request channel and a registered response. The response arrives one cycle after acceptance and carries read data and an error flag. When both ports request in the same cycle, the scan port wins. The bank drives the host decode window base and its enable straight from the base register.

Top module: `svc_bridge_regbank`

## Requirements
- R1: After reset, every register reads zero except the window base register, which holds the parameter BAR_RST masked to its legal bits. The outputs `win_en_o`/`win_base_o` reflect that value, and both ports' response valids are low.
- R2: The register index is `addr>>3` on the scan port and `(addr>>3)+0x0A` on the memory-mapped port. The index map is: 0x00 fault, 0x01 fault-AND, 0x02 fault-OR, 0x06/0x07 fault actions, 0x0A window base, 0x0B service base, 0x0E control, 0x0F error mask, 0x12 control-set, 0x13 control-clear, 0x14 DMA upper.
- R3: A write at index 0x01 replaces the fault register with its AND with the data. A write at index 0x02 replaces it with its OR with the data.
- R4: A write at index 0x12 ORs the data into the control register. A write at index 0x13 clears the control bits that are set in the data.
- R5: A window base write keeps only bits 0x0003FFFFFFF00000 plus bit 0. `win_base_o` is the stored value without bit 0, and `win_en_o` equals stored bit 0.
- R6: A window base write from the memory-mapped port is rejected with an error response and leaves the register unchanged.
- R7: A service base write keeps only bits 0x0003FFFF00000000.
- R8: Indices 0x00, 0x06, 0x07, 0x0E, 0x0F and 0x14 store the full 64-bit write data and read it back unchanged.
- R9: A read of an index outside {0x00,0x06,0x07,0x0A,0x0B,0x0E,0x0F,0x14}, including the write-only aliases, returns all ones with the error flag set. A write to an index with no register or alias returns an error and changes nothing. Every error response carries all-ones data.
- R10: An access whose address bits [2:0] are not zero is not an 8-byte access. It is answered with an error and all-ones data, and it changes nothing.
- R11: When both ports are valid in one cycle, the scan port is accepted and the memory-mapped port's ready is low. The memory-mapped request is served on a later cycle.
- R12: Each accepted request produces exactly one response on its own port, one cycle after acceptance. A successful write responds with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sc_valid_i | input | 1 | Scan port request valid |
| sc_ready_o | output | 1 | Scan port request accepted |
| sc_we_i | input | 1 | Scan port write (1) or read (0) |
| sc_addr_i | input | ADDR_W | Scan port byte address |
| sc_wdata_i | input | 64 | Scan port write data |
| sc_rsp_valid_o | output | 1 | Scan port response valid |
| sc_rsp_rdata_o | output | 64 | Scan port response data |
| sc_rsp_err_o | output | 1 | Scan port response error |
| mm_valid_i | input | 1 | Memory-mapped port request valid |
| mm_ready_o | output | 1 | Memory-mapped port request accepted |
| mm_we_i | input | 1 | Memory-mapped port write (1) or read (0) |
| mm_addr_i | input | ADDR_W | Memory-mapped port byte address |
| mm_wdata_i | input | 64 | Memory-mapped port write data |
| mm_rsp_valid_o | output | 1 | Memory-mapped port response valid |
| mm_rsp_rdata_o | output | 64 | Memory-mapped port response data |
| mm_rsp_err_o | output | 1 | Memory-mapped port response error |
| win_base_o | output | 64 | Host decode window base address |
| win_en_o | output | 1 | Host decode window enable |

## Verification
The bench targets the corner cases where a wrong design still looks plausible. A window base write from the memory-mapped port must fail; a design that forgot the port check would move the decode window. Aliases must fold into their target instead of being stored or read back; a wrong design would return alias data or lose fault bits. Misaligned and unmapped accesses must answer all ones with an error and write nothing. A design that truncated the address would corrupt the fault register. A simultaneous request from both ports must serve the scan port first and then the memory-mapped port. A design that dropped or swapped one would leave a response missing or on the wrong port.

// File: rtl/svc_regbank_pkg.sv
package svc_regbank_pkg;
  localparam int unsigned DW = 64;

  localparam logic [7:0] IX_FLT      = 8'h00;
  localparam logic [7:0] IX_FLT_AND  = 8'h01;
  localparam logic [7:0] IX_FLT_OR   = 8'h02;
  localparam logic [7:0] IX_ACT0     = 8'h06;
  localparam logic [7:0] IX_ACT1     = 8'h07;
  localparam logic [7:0] IX_WBASE    = 8'h0A;
  localparam logic [7:0] IX_SBASE    = 8'h0B;
  localparam logic [7:0] IX_CTL      = 8'h0E;
  localparam logic [7:0] IX_EMASK    = 8'h0F;
  localparam logic [7:0] IX_CTL_SET  = 8'h12;
  localparam logic [7:0] IX_CTL_CLR  = 8'h13;
  localparam logic [7:0] IX_DMA_UP   = 8'h14;

  localparam logic [7:0] MM_IX_BIAS  = IX_WBASE;

  localparam logic [DW-1:0] WBASE_ADDR_MASK = 64'h0003_FFFF_FFF0_0000;
  localparam logic [DW-1:0] WBASE_KEEP_MASK = WBASE_ADDR_MASK | 64'h1;
  localparam logic [DW-1:0] SBASE_KEEP_MASK = 64'h0003_FFFF_0000_0000;

  typedef enum logic {PORT_SC = 1'b0, PORT_MM = 1'b1} port_e;
endpackage

// File: rtl/svc_port_arb.sv
module svc_port_arb
  import svc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IDX_W = ADDR_W - 3
) (
  input  logic              sc_valid_i,
  input  logic              sc_we_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [DW-1:0]     sc_wdata_i,
  input  logic              mm_valid_i,
  input  logic              mm_we_i,
  input  logic [ADDR_W-1:0] mm_addr_i,
  input  logic [DW-1:0]     mm_wdata_i,
  output logic              sc_ready_o,
  output logic              mm_ready_o,
  output logic              gnt_v_o,
  output port_e             gnt_port_o,
  output logic              gnt_we_o,
  output logic              gnt_align_o,
  output logic [IDX_W-1:0]  gnt_idx_o,
  output logic [DW-1:0]     gnt_wdata_o
);
  logic [IDX_W-1:0] sc_idx, mm_idx;

  assign sc_idx = sc_addr_i[ADDR_W-1:3];
  assign mm_idx = mm_addr_i[ADDR_W-1:3] + IDX_W'(MM_IX_BIAS);

  assign sc_ready_o = 1'b1;
  assign mm_ready_o = ~sc_valid_i;

  always_comb begin
    gnt_v_o = sc_valid_i | mm_valid_i;
    if (sc_valid_i) begin
      gnt_port_o  = PORT_SC;
      gnt_we_o    = sc_we_i;
      gnt_align_o = (sc_addr_i[2:0] == 3'b000);
      gnt_idx_o   = sc_idx;
      gnt_wdata_o = sc_wdata_i;
    end else begin
      gnt_port_o  = PORT_MM;
      gnt_we_o    = mm_we_i;
      gnt_align_o = (mm_addr_i[2:0] == 3'b000);
      gnt_idx_o   = mm_idx;
      gnt_wdata_o = mm_wdata_i;
    end
  end
endmodule

// File: rtl/svc_reg_file.sv
module svc_reg_file
  import svc_regbank_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  parameter logic [DW-1:0] BAR_RST = 64'h0000_0003_FFF0_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_v_i,
  input  port_e            req_port_i,
  input  logic             req_we_i,
  input  logic             req_align_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             err_o,
  output logic [DW-1:0]    win_base_o,
  output logic             win_en_o
);
  logic [DW-1:0] flt_q, act0_q, act1_q, wbase_q, sbase_q, ctl_q, emask_q, dma_q;
  logic rd_ok, wr_ok, do_wr;
  logic [DW-1:0] rd_val;

  function automatic logic at(input logic [IDX_W-1:0] idx, input logic [7:0] off);
    return idx == IDX_W'(off);
  endfunction

  always_comb begin
    rd_ok  = 1'b1;
    rd_val = '1;
    unique case (1'b1)
      at(req_idx_i, IX_FLT):    rd_val = flt_q;
      at(req_idx_i, IX_ACT0):   rd_val = act0_q;
      at(req_idx_i, IX_ACT1):   rd_val = act1_q;
      at(req_idx_i, IX_WBASE):  rd_val = wbase_q;
      at(req_idx_i, IX_SBASE):  rd_val = sbase_q;
      at(req_idx_i, IX_CTL):    rd_val = ctl_q;
      at(req_idx_i, IX_EMASK):  rd_val = emask_q;
      at(req_idx_i, IX_DMA_UP): rd_val = dma_q;
      default:                  rd_ok  = 1'b0;
    endcase
  end

  always_comb begin
    wr_ok = rd_ok | at(req_idx_i, IX_FLT_AND) | at(req_idx_i, IX_FLT_OR)
                  | at(req_idx_i, IX_CTL_SET) | at(req_idx_i, IX_CTL_CLR);
    // window base is owned by the scan port only
    if (at(req_idx_i, IX_WBASE) && req_port_i == PORT_MM) wr_ok = 1'b0;
  end

  assign err_o   = ~req_align_i | (req_we_i ? ~wr_ok : ~rd_ok);
  assign rdata_o = err_o ? '1 : (req_we_i ? '0 : rd_val);
  assign do_wr   = req_v_i & req_we_i & ~err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q   <= '0;
      act0_q  <= '0;
      act1_q  <= '0;
      wbase_q <= BAR_RST & WBASE_KEEP_MASK;
      sbase_q <= '0;
      ctl_q   <= '0;
      emask_q <= '0;
      dma_q   <= '0;
    end else if (do_wr) begin
      if (at(req_idx_i, IX_FLT))     flt_q   <= req_wdata_i;
      if (at(req_idx_i, IX_FLT_AND)) flt_q   <= flt_q & req_wdata_i;
      if (at(req_idx_i, IX_FLT_OR))  flt_q   <= flt_q | req_wdata_i;
      if (at(req_idx_i, IX_ACT0))    act0_q  <= req_wdata_i;
      if (at(req_idx_i, IX_ACT1))    act1_q  <= req_wdata_i;
      if (at(req_idx_i, IX_WBASE))   wbase_q <= req_wdata_i & WBASE_KEEP_MASK;
      if (at(req_idx_i, IX_SBASE))   sbase_q <= req_wdata_i & SBASE_KEEP_MASK;
      if (at(req_idx_i, IX_CTL))     ctl_q   <= req_wdata_i;
      if (at(req_idx_i, IX_CTL_SET)) ctl_q   <= ctl_q | req_wdata_i;
      if (at(req_idx_i, IX_CTL_CLR)) ctl_q   <= ctl_q & ~req_wdata_i;
      if (at(req_idx_i, IX_EMASK))   emask_q <= req_wdata_i;
      if (at(req_idx_i, IX_DMA_UP))  dma_q   <= req_wdata_i;
    end
  end

  assign win_base_o = wbase_q & WBASE_ADDR_MASK;
  assign win_en_o   = wbase_q[0];
endmodule

// File: rtl/svc_bridge_regbank.sv
module svc_bridge_regbank
  import svc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [63:0] BAR_RST = 64'h0000_0003_FFF0_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_valid_i,
  output logic              sc_ready_o,
  input  logic              sc_we_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [63:0]       sc_wdata_i,
  output logic              sc_rsp_valid_o,
  output logic [63:0]       sc_rsp_rdata_o,
  output logic              sc_rsp_err_o,
  input  logic              mm_valid_i,
  output logic              mm_ready_o,
  input  logic              mm_we_i,
  input  logic [ADDR_W-1:0] mm_addr_i,
  input  logic [63:0]       mm_wdata_i,
  output logic              mm_rsp_valid_o,
  output logic [63:0]       mm_rsp_rdata_o,
  output logic              mm_rsp_err_o,
  output logic [63:0]       win_base_o,
  output logic              win_en_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;
  localparam int unsigned NPORT = 2;

  logic             gnt_v, gnt_we, gnt_align, f_err;
  port_e            gnt_port;
  logic [IDX_W-1:0] gnt_idx;
  logic [DW-1:0]    gnt_wdata, f_rdata;

  logic [NPORT-1:0] rsp_v_q, rsp_e_q;
  logic [DW-1:0]    rsp_d_q [NPORT];

  svc_port_arb #(.ADDR_W(ADDR_W)) u_arb (
    .sc_valid_i (sc_valid_i), .sc_we_i (sc_we_i), .sc_addr_i (sc_addr_i), .sc_wdata_i (sc_wdata_i),
    .mm_valid_i (mm_valid_i), .mm_we_i (mm_we_i), .mm_addr_i (mm_addr_i), .mm_wdata_i (mm_wdata_i),
    .sc_ready_o (sc_ready_o), .mm_ready_o (mm_ready_o),
    .gnt_v_o (gnt_v), .gnt_port_o (gnt_port), .gnt_we_o (gnt_we),
    .gnt_align_o (gnt_align), .gnt_idx_o (gnt_idx), .gnt_wdata_o (gnt_wdata)
  );

  svc_reg_file #(.IDX_W(IDX_W), .BAR_RST(BAR_RST)) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_v_i (gnt_v), .req_port_i (gnt_port), .req_we_i (gnt_we),
    .req_align_i (gnt_align), .req_idx_i (gnt_idx), .req_wdata_i (gnt_wdata),
    .rdata_o (f_rdata), .err_o (f_err),
    .win_base_o (win_base_o), .win_en_o (win_en_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_v_q[p] <= 1'b0;
        rsp_e_q[p] <= 1'b0;
        rsp_d_q[p] <= '0;
      end else begin
        rsp_v_q[p] <= gnt_v && (int'(gnt_port) == p);
        if (gnt_v && (int'(gnt_port) == p)) begin
          rsp_e_q[p] <= f_err;
          rsp_d_q[p] <= f_rdata;
        end
      end
    end
  end

  assign sc_rsp_valid_o = rsp_v_q[0];
  assign sc_rsp_err_o   = rsp_e_q[0];
  assign sc_rsp_rdata_o = rsp_d_q[0];
  assign mm_rsp_valid_o = rsp_v_q[1];
  assign mm_rsp_err_o   = rsp_e_q[1];
  assign mm_rsp_rdata_o = rsp_d_q[1];
endmodule

// File: rtl/svc_bridge_regbank_chk.sv
module svc_bridge_regbank_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sc_valid_i,
  input logic              sc_ready_o,
  input logic              sc_we_i,
  input logic [ADDR_W-1:0] sc_addr_i,
  input logic              sc_rsp_valid_o,
  input logic [63:0]       sc_rsp_rdata_o,
  input logic              sc_rsp_err_o,
  input logic              mm_valid_i,
  input logic              mm_ready_o,
  input logic              mm_we_i,
  input logic [ADDR_W-1:0] mm_addr_i,
  input logic              mm_rsp_valid_o,
  input logic [63:0]       mm_rsp_rdata_o,
  input logic              mm_rsp_err_o,
  input logic [63:0]       win_base_o,
  input logic              win_en_o
);
  logic sc_acc, mm_acc, mm_bar_wr;
  assign sc_acc    = sc_valid_i & sc_ready_o;
  assign mm_acc    = mm_valid_i & mm_ready_o;
  assign mm_bar_wr = mm_acc & mm_we_i & (mm_addr_i == '0);

  AST_SC_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_acc |=> sc_rsp_valid_o); // R12
  AST_MM_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_acc |=> mm_rsp_valid_o); // R12
  AST_MM_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mm_acc |=> !mm_rsp_valid_o); // R12
  AST_SCAN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_valid_i |-> (sc_ready_o && !mm_ready_o)); // R11
  AST_MM_BAR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_bar_wr |=> mm_rsp_err_o); // R6
  AST_MM_BAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_bar_wr |=> ($stable(win_base_o) && $stable(win_en_o))); // R6
  AST_MISALIGN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_acc && sc_addr_i[2:0] != 3'b000) |=> sc_rsp_err_o); // R10
  AST_SC_ERR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_rsp_valid_o && sc_rsp_err_o) |-> (sc_rsp_rdata_o == '1)); // R9
  AST_MM_ERR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_rsp_valid_o && mm_rsp_err_o) |-> (mm_rsp_rdata_o == '1)); // R9
endmodule

bind svc_bridge_regbank svc_bridge_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni),
  .sc_valid_i (sc_valid_i), .sc_ready_o (sc_ready_o), .sc_we_i (sc_we_i), .sc_addr_i (sc_addr_i),
  .sc_rsp_valid_o (sc_rsp_valid_o), .sc_rsp_rdata_o (sc_rsp_rdata_o), .sc_rsp_err_o (sc_rsp_err_o),
  .mm_valid_i (mm_valid_i), .mm_ready_o (mm_ready_o), .mm_we_i (mm_we_i), .mm_addr_i (mm_addr_i),
  .mm_rsp_valid_o (mm_rsp_valid_o), .mm_rsp_rdata_o (mm_rsp_rdata_o), .mm_rsp_err_o (mm_rsp_err_o),
  .win_base_o (win_base_o), .win_en_o (win_en_o)
);

// File: tb/sim_svc_bridge_regbank.sv
module sim_svc_bridge_regbank;
  localparam int unsigned AW = 16;

  typedef struct packed {
    logic        mm;
    logic        we;
    logic [15:0] addr;
    logic [63:0] wdata;
    logic [63:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = '1;
  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 16'h0000, 64'h0, 64'h0, 1'b0, 8'd1},                                     // R1 fault zero
    '{1'b0, 1'b1, 16'h0000, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0, 1'b0, 8'd8},
    '{1'b0, 1'b1, 16'h0008, 64'hFF00_FF00_FF00_FF00, 64'h0, 1'b0, 8'd3},
    '{1'b0, 1'b0, 16'h0000, 64'h0, 64'hF000_F000_F000_F000, 1'b0, 8'd3},                 // R3 AND
    '{1'b0, 1'b1, 16'h0010, 64'h0000_0000_0000_000F, 64'h0, 1'b0, 8'd3},
    '{1'b0, 1'b0, 16'h0000, 64'h0, 64'hF000_F000_F000_F00F, 1'b0, 8'd3},                 // R3 OR
    '{1'b0, 1'b1, 16'h0070, 64'h1234_0000_0000_0000, 64'h0, 1'b0, 8'd8},
    '{1'b1, 1'b1, 16'h0040, 64'h0000_0000_0000_00FF, 64'h0, 1'b0, 8'd4},                 // R4 set via mm
    '{1'b1, 1'b1, 16'h0048, 64'h1200_0000_0000_000F, 64'h0, 1'b0, 8'd4},                 // R4 clear via mm
    '{1'b1, 1'b0, 16'h0020, 64'h0, 64'h0034_0000_0000_00F0, 1'b0, 8'd2},                 // R2 R4
    '{1'b0, 1'b1, 16'h0050, ONES, 64'h0, 1'b0, 8'd5},
    '{1'b0, 1'b0, 16'h0050, 64'h0, 64'h0003_FFFF_FFF0_0001, 1'b0, 8'd5},                 // R5 mask
    '{1'b1, 1'b1, 16'h0000, 64'h0, ONES, 1'b1, 8'd6},                                    // R6 reject
    '{1'b1, 1'b0, 16'h0000, 64'h0, 64'h0003_FFFF_FFF0_0001, 1'b0, 8'd6},                 // R6 unchanged
    '{1'b0, 1'b1, 16'h0058, ONES, 64'h0, 1'b0, 8'd7},
    '{1'b0, 1'b0, 16'h0058, 64'h0, 64'h0003_FFFF_0000_0000, 1'b0, 8'd7},                 // R7
    '{1'b0, 1'b1, 16'h0030, 64'hDEAD_BEEF_0123_4567, 64'h0, 1'b0, 8'd8},
    '{1'b0, 1'b0, 16'h0030, 64'h0, 64'hDEAD_BEEF_0123_4567, 1'b0, 8'd8},                 // R8 act0
    '{1'b1, 1'b1, 16'h0050, 64'hA5A5_5A5A_A5A5_5A5A, 64'h0, 1'b0, 8'd8},
    '{1'b0, 1'b0, 16'h00A0, 64'h0, 64'hA5A5_5A5A_A5A5_5A5A, 1'b0, 8'd2},                 // R2 R8 dma
    '{1'b1, 1'b1, 16'h0028, 64'h0F0F_0000_1234_ABCD, 64'h0, 1'b0, 8'd8},
    '{1'b0, 1'b0, 16'h0078, 64'h0, 64'h0F0F_0000_1234_ABCD, 1'b0, 8'd8},                 // R8 emask
    '{1'b0, 1'b0, 16'h0008, 64'h0, ONES, 1'b1, 8'd9},                                    // R9 alias read
    '{1'b0, 1'b0, 16'h0018, 64'h0, ONES, 1'b1, 8'd9},                                    // R9 hole read
    '{1'b0, 1'b1, 16'h0018, 64'h1111, ONES, 1'b1, 8'd9},                                 // R9 hole write
    '{1'b0, 1'b1, 16'h0001, 64'h0, ONES, 1'b1, 8'd10},                                   // R10 misaligned write
    '{1'b0, 1'b0, 16'h0000, 64'h0, 64'hF000_F000_F000_F00F, 1'b0, 8'd10}                 // R10 no effect
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sc_valid = 0, sc_we = 0, mm_valid = 0, mm_we = 0;
  logic [AW-1:0] sc_addr = '0, mm_addr = '0;
  logic [63:0] sc_wdata = '0, mm_wdata = '0;
  logic sc_ready, mm_ready, sc_rv, sc_re, mm_rv, mm_re, win_en;
  logic [63:0] sc_rd, mm_rd, win_base;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  svc_bridge_regbank #(.ADDR_W(AW)) u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .sc_valid_i (sc_valid), .sc_ready_o (sc_ready), .sc_we_i (sc_we), .sc_addr_i (sc_addr), .sc_wdata_i (sc_wdata),
    .sc_rsp_valid_o (sc_rv), .sc_rsp_rdata_o (sc_rd), .sc_rsp_err_o (sc_re),
    .mm_valid_i (mm_valid), .mm_ready_o (mm_ready), .mm_we_i (mm_we), .mm_addr_i (mm_addr), .mm_wdata_i (mm_wdata),
    .mm_rsp_valid_o (mm_rv), .mm_rsp_rdata_o (mm_rd), .mm_rsp_err_o (mm_re),
    .win_base_o (win_base), .win_en_o (win_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input vec_t v);
    @(negedge clk);
    if (v.mm) begin
      mm_valid = 1; mm_we = v.we; mm_addr = v.addr; mm_wdata = v.wdata;
    end else begin
      sc_valid = 1; sc_we = v.we; sc_addr = v.addr; sc_wdata = v.wdata;
    end
    @(negedge clk);
    sc_valid = 0; mm_valid = 0;
    if (v.mm) chk($sformatf("R12 vec R%0d rsp", v.req), {63'b0, mm_rv}, 64'h1);
    else      chk($sformatf("R12 vec R%0d rsp", v.req), {63'b0, sc_rv}, 64'h1);
    chk($sformatf("R%0d data a=%h", v.req, v.addr), v.mm ? mm_rd : sc_rd, v.exp);
    chk($sformatf("R%0d err a=%h", v.req, v.addr), {63'b0, v.mm ? mm_re : sc_re}, {63'b0, v.err});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 win_en", {63'b0, win_en}, 64'h1);
    chk("R1 win_base", win_base, 64'h0000_0003_FFF0_0000);
    chk("R1 rsp idle", {62'b0, sc_rv, mm_rv}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i]);
      if (i == 11) begin
        chk("R5 win_en set", {63'b0, win_en}, 64'h1);
        chk("R5 win_base", win_base, 64'h0003_FFFF_FFF0_0000);
      end
      if (i == 13) chk("R6 win_base held", win_base, 64'h0003_FFFF_FFF0_0000);
    end

    access('{1'b0, 1'b1, 16'h0050, 64'h0000_0001_0000_0000, 64'h0, 1'b0, 8'd5});
    chk("R5 win_en cleared", {63'b0, win_en}, 64'h0);
    chk("R5 win_base", win_base, 64'h0000_0001_0000_0000);

    // R11 simultaneous requests
    @(negedge clk);
    sc_valid = 1; sc_we = 0; sc_addr = 16'h0000;
    mm_valid = 1; mm_we = 0; mm_addr = 16'h0020;
    #1;
    chk("R11 ready pair", {62'b0, sc_ready, mm_ready}, 64'h2);
    @(negedge clk);
    sc_valid = 0;
    chk("R11 scan rsp first", {62'b0, sc_rv, mm_rv}, 64'h2);
    chk("R11 scan data", sc_rd, 64'hF000_F000_F000_F00F);
    #1;
    chk("R11 mm ready after", {63'b0, mm_ready}, 64'h1);
    @(negedge clk);
    mm_valid = 0;
    chk("R11 mm rsp later", {62'b0, sc_rv, mm_rv}, 64'h1);
    chk("R11 mm data", mm_rd, 64'h0034_0000_0000_00F0);
    @(negedge clk);
    chk("R12 no extra rsp", {62'b0, sc_rv, mm_rv}, 64'h0);

    // R1 reset restores defaults
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    access('{1'b0, 1'b0, 16'h0070, 64'h0, 64'h0, 1'b0, 8'd1});
    chk("R1 win_en after reset", {63'b0, win_en}, 64'h1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule